// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block fills a wide configuration register from a one-bit serial source, such as a small ROM or a few gates of glue logic, as soon as power is declared good. It derives a slow serial clock from the main clock, drives that clock out to the source, and captures one mode bit on each rising edge of it. When the last bit has been taken it raises a done flag. From then on the serial clock keeps toggling, but nothing more is captured.

The sequence has no start command. The rising level of the power-good input starts it. Dropping power-good returns the loader to its idle state, and the next assertion runs a complete fresh load. The contents of the configuration register are passed through without any decoding.

Top module: `boot_cfg_loader`

## Requirements
- R1: While `pwr_good_i` is high, `ser_clk_o` is periodic with a period of `DIV` clock cycles: `DIV/2` cycles high, then `DIV/2` cycles low.
- R2: While `pwr_good_i` is low, `ser_clk_o` is held low from the next clock edge on.
- R3: The first rising edge of `ser_clk_o` comes `DIV/2` clock edges after `pwr_good_i` is first sampled high. `mode_bit_i` is sampled on the clock edge that raises `ser_clk_o`.
- R4: Each load captures exactly `NBITS` bits. The k-th bit sampled, counting from 0, ends up in `cfg_o[k]`.
- R5: After the last bit has been captured, `ser_clk_o` keeps toggling, and `cfg_o` stays unchanged whatever `mode_bit_i` does.
- R6: `done_o` rises on the clock edge that captures bit `NBITS-1`, and stays high for as long as `pwr_good_i` stays high.
- R7: A low `pwr_good_i` clears `done_o` and the bit count at the next edge. The next assertion then reloads all `NBITS` bits.
- R8: During reset, `ser_clk_o` is low, `done_o` is low and `cfg_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Power-good level, synchronous to clk_i; starts a load when high |
| mode_bit_i | input | 1 | Serial mode bit from the external source |
| ser_clk_o | output | 1 | Divided serial clock driven to the source |
| cfg_o | output | NBITS | Captured configuration, bit k = k-th bit read |
| done_o | output | 1 | All NBITS bits captured |

## Verification
The bench builds the loader with `DIV=8` and `NBITS=16`. With these values a full load takes 128 cycles, so the bench can afford several complete loads per run. This makes reachable the last-bit boundary where `done_o` rises, the free-running clock after completion, and a power-good drop in the middle of a load. The bench also measures the serial clock's high and low halves and its start-up delay directly. These timings scale with `DIV` in the same way at the default of 256.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int unsigned DEF_DIV   = 256;
  localparam int unsigned DEF_NBITS = 256;

  function automatic bit is_pow2(int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/bcl_clk_div.sv
module bcl_clk_div #(
  parameter int unsigned DIV = boot_cfg_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ser_clk_o,
  output logic sample_o
);
  localparam int unsigned W = $clog2(DIV);
  localparam logic [W-1:0] HALF_M1 = W'(DIV / 2 - 1);

  logic [W-1:0] cnt_q;

  initial begin
    assert (boot_cfg_pkg::is_pow2(DIV)) else $error("DIV must be a power of two");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // MSB high for the upper half of the count
  assign ser_clk_o = cnt_q[W-1];
  // strobe on the edge that makes the MSB rise
  assign sample_o  = run_i && (cnt_q == HALF_M1);

  AST_RISE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> ser_clk_o);  // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !ser_clk_o);  // R2
endmodule

// File: rtl/bcl_bit_ctr.sv
module bcl_bit_ctr #(
  parameter int unsigned NBITS = boot_cfg_pkg::DEF_NBITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sample_i,
  output logic capture_o,
  output logic done_o
);
  localparam int unsigned CW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign capture_o = sample_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (capture_o) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && run_i) |=> $stable(cnt_q));  // R5
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);  // R4
endmodule

// File: rtl/bcl_shift_reg.sv
module bcl_shift_reg #(
  parameter int unsigned NBITS = boot_cfg_pkg::DEF_NBITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [NBITS-1:0] q_o
);
  logic [NBITS-1:0] q_q;

  // shift toward LSB: first bit in lands at bit 0 after NBITS shifts
  for (genvar i = 0; i < NBITS; i++) begin : g_stage
    logic nxt;
    if (i == NBITS - 1) begin : g_top
      assign nxt = din_i;
    end else begin : g_mid
      assign nxt = q_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_q[i] <= 1'b0;
      else if (shift_i) q_q[i] <= nxt;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader #(
  parameter int unsigned DIV   = boot_cfg_pkg::DEF_DIV,
  parameter int unsigned NBITS = boot_cfg_pkg::DEF_NBITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             mode_bit_i,
  output logic             ser_clk_o,
  output logic [NBITS-1:0] cfg_o,
  output logic             done_o
);
  logic sample;
  logic capture;

  bcl_clk_div #(.DIV(DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (pwr_good_i),
    .ser_clk_o (ser_clk_o),
    .sample_o  (sample)
  );

  bcl_bit_ctr #(.NBITS(NBITS)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (pwr_good_i),
    .sample_i  (sample),
    .capture_o (capture),
    .done_o    (done_o)
  );

  bcl_shift_reg #(.NBITS(NBITS)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (capture),
    .din_i   (mode_bit_i),
    .q_o     (cfg_o)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pwr_good_i) |=> $stable(cfg_o));  // R5
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pwr_good_i) |=> done_o);  // R6
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !done_o);  // R7
  AST_CFG_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $rose(ser_clk_o));  // R4
  AST_DONE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $rose(ser_clk_o));  // R6
endmodule

// File: tb/boot_cfg_loader_bench.sv
module boot_cfg_loader_bench;
  localparam int unsigned DIV   = 8;
  localparam int unsigned NBITS = 16;
  localparam int unsigned NVEC  = 4;

  // {stimulus bit stream (bit k sent k-th), expected cfg_o}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'hA5C3, 16'hA5C3},
    {16'hFFFF, 16'hFFFF},
    {16'h0000, 16'h0000},
    {16'h8001, 16'h8001}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pwr_good_i = 1'b0;
  logic             mode_bit_i = 1'b0;
  logic             ser_clk_o;
  logic [NBITS-1:0] cfg_o;
  logic             done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  boot_cfg_loader #(.DIV(DIV), .NBITS(NBITS)) u_boot_cfg_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .mode_bit_i (mode_bit_i),
    .ser_clk_o  (ser_clk_o),
    .cfg_o      (cfg_o),
    .done_o     (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [NBITS-1:0] pat);
    mode_bit_i = pat[0];
    pwr_good_i = 1'b1;
    for (int k = 0; k < NBITS; k++) begin
      @(posedge ser_clk_o);
      @(negedge clk_i);
      if (k == NBITS - 2) chk(done_o == 1'b0, "R6 done before last bit", 32'(done_o), 0);
      if (k < NBITS - 1) mode_bit_i = pat[k+1];
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(ser_clk_o == 1'b0, "R8 ser_clk in reset", 32'(ser_clk_o), 0);
    chk(done_o == 1'b0, "R8 done in reset", 32'(done_o), 0);
    chk(cfg_o == '0, "R8 cfg in reset", 32'(cfg_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // vector table: full loads
    for (int v = 0; v < NVEC; v++) begin
      load(VEC[v][31:16]);
      chk(done_o == 1'b1, "R6 done after last bit", 32'(done_o), 1);
      chk(cfg_o == VEC[v][15:0], "R4 cfg contents", 32'(cfg_o), 32'(VEC[v][15:0]));
      pwr_good_i = 1'b0;
      @(negedge clk_i);
      chk(done_o == 1'b0, "R7 done cleared", 32'(done_o), 0);
      @(negedge clk_i);
    end

    // R2 clock idle while power-good low
    repeat (DIV) @(negedge clk_i);
    chk(ser_clk_o == 1'b0, "R2 ser_clk idle", 32'(ser_clk_o), 0);

    // R3 start-up delay
    pwr_good_i = 1'b1;
    n = 0;
    while (!ser_clk_o && n < 4 * DIV) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == DIV / 2, "R3 first rise delay", 32'(n), DIV / 2);

    // R1 high and low halves
    n = 0;
    while (ser_clk_o && n < 4 * DIV) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == DIV / 2, "R1 high half", 32'(n), DIV / 2);
    n = 0;
    while (!ser_clk_o && n < 4 * DIV) begin
      @(negedge clk_i);
      n++;
    end
    chk(n == DIV / 2, "R1 low half", 32'(n), DIV / 2);
    pwr_good_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R7 drop mid-load, then full reload
    mode_bit_i = 1'b1;
    pwr_good_i = 1'b1;
    repeat (5) @(posedge ser_clk_o);
    @(negedge clk_i);
    pwr_good_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done low after abort", 32'(done_o), 0);
    load(16'h3C96);
    chk(done_o == 1'b1, "R7 done after reload", 32'(done_o), 1);
    chk(cfg_o == 16'h3C96, "R7 full reload", 32'(cfg_o), 32'h3C96);

    // R5 after done: clock runs, cfg frozen
    n = 0;
    for (int c = 0; c < 3 * DIV; c++) begin
      logic prev;
      prev = ser_clk_o;
      mode_bit_i = ~mode_bit_i;
      @(negedge clk_i);
      if (!prev && ser_clk_o) n++;
    end
    chk(n == 3, "R5 ser_clk keeps running", 32'(n), 3);
    chk(cfg_o == 16'h3C96, "R5 cfg unchanged", 32'(cfg_o), 32'h3C96);
    chk(done_o == 1'b1, "R6 done held", 32'(done_o), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule